// File: doc/BRIEF.md
# Length-Prefixed Command Stream Player

This block plays out configuration records for a display controller from a small internal read-only table. Each record in the table carries its own length: a count byte N, then an opcode byte, then exactly N parameter bytes. The player does not transmit the count byte. It sends the opcode as a command byte and each parameter as a data byte. The result is a byte stream with a command/data flag, ready for a downstream serial shifter.

A one-cycle start pulse captures three values: a table base address, a table length in bytes, and a mode select. The mode select chooses one of two table banks, black-and-white (0) or grayscale (1). Inside each bank, the pre-power-on records and the post-power-on records sit in separate regions, so a caller plays one region by choosing its base and length. When the byte index reaches base plus length, the block pulses done. If a record cannot be completed inside the window, or declares more parameters than allowed, the block pulses error together with done.

The output is a valid/ready byte stream. A byte is accepted only on a clock edge where valid and ready are both high. While valid is high and ready is low, the byte and its flag stay unchanged and valid stays high. Ready may stay low for any number of cycles, and no byte is dropped or repeated. Start, mode, base, length, done and error are plain level or pulse pins.

Top module: `cmd_stream_player`

## Requirements
- R1: After reset, tx_valid_o, done_o and err_o are low.
- R2: start_i is sampled only while the player is idle, and it captures base_i, len_i and mode_i. A start pulse during playback has no effect on the byte stream.
- R3: For a record whose count byte is N, the count byte is not sent. The next byte (the opcode) is sent with tx_cmd_o=1. The following N bytes are sent in table order with tx_cmd_o=0.
- R4: A byte advances only on an edge where tx_valid_o and tx_ready_i are both high. While valid is high and ready is low, valid, tx_data_o and tx_cmd_o hold their values.
- R5: Playback ends exactly when the byte index equals base_i+len_i. At that point done_o pulses high for one cycle with err_o low. A length of 0 gives done with no byte sent.
- R6: A count byte greater than 6, or one whose record would run past base_i+len_i, raises err_o and done_o together for one cycle. No byte of that record is sent.
- R7: Black-and-white bank (mode 0): the pre-power region is at 0, 11 bytes long. It holds a power record (count 4, opcode 0x01, parameters 0x03 0x00 0x2B 0x2B) and a boost record (count 3, opcode 0x06, parameters 0x17 0x17 0x17). The post-power region is at 11, 10 bytes long. It holds a panel-setting record (opcode 0x00, parameters 0xBF 0x0D) and a resolution record (opcode 0x61, parameters 0x01 0x90 0x01 0x2C, which is 400 by 300 as high/low byte pairs).
- R8: Grayscale bank (mode 1): the pre-power region is at 0, 12 bytes long. It holds a power record (count 5, opcode 0x01, parameters 0x03 0x00 0x2B 0x2B 0x13) and the same boost record. The post-power region is at 12, 9 bytes long. It holds a panel-setting record (opcode 0x00, parameter 0x3F) and the same resolution record.
- R9: In both banks, byte 24 holds 0x07 and all other bytes up to 31 hold 0x00. A zero count byte yields an opcode-only record.
- R10: done_o is never high in two consecutive cycles, err_o is high only together with done_o, and tx_valid_o is low while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| mode_i | input | 1 | Bank select: 0 black-and-white, 1 grayscale |
| base_i | input | 5 | First table byte of the window |
| len_i | input | 6 | Window length in bytes (base_i+len_i at most 32) |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| tx_data_o | output | 8 | Output byte |
| tx_cmd_o | output | 1 | 1 for an opcode byte, 0 for a parameter byte |
| done_o | output | 1 | One-cycle pulse at the end of playback |
| err_o | output | 1 | One-cycle pulse with done_o on a malformed record |

## Verification
The bench builds the block with its default parameters: a 32-byte table per bank and at most 6 parameters per record. With these values, a window ending at the last table byte can be reached, and so can the 0x07 count that exceeds the parameter limit. Random windows that start in the middle of a record reach the overrun check from many alignments, and random back-pressure exercises the hold rule on both command and data bytes.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_SEND
  } walk_st_e;

  // Table image: bank 0 black-and-white, bank 1 grayscale.
  function automatic logic [7:0] table_byte(input int bank, input int addr);
    logic [7:0] v;
    v = 8'h00;
    if (addr == 24) v = 8'h07;  // deliberately oversized count
    else if (bank == 0) begin
      case (addr)
        0: v = 8'h04;  1: v = 8'h01;  2: v = 8'h03;  3: v = 8'h00;
        4: v = 8'h2B;  5: v = 8'h2B;  6: v = 8'h03;  7: v = 8'h06;
        8: v = 8'h17;  9: v = 8'h17; 10: v = 8'h17; 11: v = 8'h02;
       12: v = 8'h00; 13: v = 8'hBF; 14: v = 8'h0D; 15: v = 8'h04;
       16: v = 8'h61; 17: v = 8'h01; 18: v = 8'h90; 19: v = 8'h01;
       20: v = 8'h2C;
        default: v = 8'h00;
      endcase
    end else begin
      case (addr)
        0: v = 8'h05;  1: v = 8'h01;  2: v = 8'h03;  3: v = 8'h00;
        4: v = 8'h2B;  5: v = 8'h2B;  6: v = 8'h13;  7: v = 8'h03;
        8: v = 8'h06;  9: v = 8'h17; 10: v = 8'h17; 11: v = 8'h17;
       12: v = 8'h01; 13: v = 8'h00; 14: v = 8'h3F; 15: v = 8'h04;
       16: v = 8'h61; 17: v = 8'h01; 18: v = 8'h90; 19: v = 8'h01;
       20: v = 8'h2C;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/cmdp_rom.sv
module cmdp_rom #(
  parameter int DEPTH = 32,
  parameter int BANKS = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic [BW-1:0] bank,
  input  logic [AW-1:0] addr,
  output logic [7:0]    rd_data
);

  logic [7:0] bank_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_comb bank_q[g] = cmdp_pkg::table_byte(g, int'(addr));
  end

  assign rd_data = bank_q[bank];

endmodule

// File: rtl/cmdp_walker.sv
module cmdp_walker #(
  parameter int DEPTH      = 32,
  parameter int MAX_PARAMS = 6,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(MAX_PARAMS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   len,
  output logic [AW-1:0] rom_addr,
  output logic          rom_bank,
  input  logic [7:0]    rom_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_cmd,
  output logic          done,
  output logic          err
);
  import cmdp_pkg::*;

  localparam logic [AW+1:0] REC_OVH = (AW+2)'(2);
  localparam logic [7:0]    MAXP8   = 8'(MAX_PARAMS);

  walk_st_e      state;
  logic [AW:0]   ptr;
  logic [AW:0]   endp;
  logic          bank_q;
  logic [CW-1:0] left;
  logic          opc;

  logic          cnt_big;
  logic [AW+1:0] rec_end;
  logic          overrun;
  logic          last_beat;

  assign cnt_big   = rom_data > MAXP8;
  assign rec_end   = {1'b0, ptr} + (AW+2)'(rom_data[CW-1:0]) + REC_OVH;
  assign overrun   = rec_end > {1'b0, endp};
  assign last_beat = opc ? (left == '0) : (left == CW'(1));

  assign rom_addr = ptr[AW-1:0];
  assign rom_bank = bank_q;
  assign tx_valid = (state == ST_SEND);
  assign tx_data  = rom_data;
  assign tx_cmd   = (state == ST_SEND) && opc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      endp   <= '0;
      bank_q <= 1'b0;
      left   <= '0;
      opc    <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ptr    <= {1'b0, base};
            endp   <= {1'b0, base} + len;
            bank_q <= mode;
            state  <= ST_HEAD;
          end
        end
        ST_HEAD: begin
          if (ptr == endp) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (cnt_big || overrun) begin
            done  <= 1'b1;
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            left  <= rom_data[CW-1:0];
            opc   <= 1'b1;
            ptr   <= ptr + 1'b1;
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            ptr <= ptr + 1'b1;
            opc <= 1'b0;
            if (!opc) left <= left - 1'b1;
            if (last_beat) state <= ST_HEAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_stream_player.sv
module cmd_stream_player #(
  parameter int DEPTH      = 32,
  parameter int MAX_PARAMS = 6,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW:0]   len_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_cmd_o,
  output logic          done_o,
  output logic          err_o
);

  logic [AW-1:0] rom_addr;
  logic          rom_bank;
  logic [7:0]    rom_data;

  cmdp_rom #(.DEPTH(DEPTH), .BANKS(2)) u_rom (
    .bank    (rom_bank),
    .addr    (rom_addr),
    .rd_data (rom_data)
  );

  cmdp_walker #(.DEPTH(DEPTH), .MAX_PARAMS(MAX_PARAMS)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .mode     (mode_i),
    .base     (base_i),
    .len      (len_i),
    .rom_addr (rom_addr),
    .rom_bank (rom_bank),
    .rom_data (rom_data),
    .tx_valid (tx_valid_o),
    .tx_ready (tx_ready_i),
    .tx_data  (tx_data_o),
    .tx_cmd   (tx_cmd_o),
    .done     (done_o),
    .err      (err_o)
  );

endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       tx_cmd_o,
  input logic       done_o,
  input logic       err_o
);

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_cmd_o)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  p_quiet_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !tx_valid_o);

  p_cmd_only_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cmd_o |-> tx_valid_o);

endmodule

bind cmd_stream_player cmdp_checker u_cmdp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_cmd_o   (tx_cmd_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/test_cmd_stream_player.sv
module test_cmd_stream_player;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [4:0] base_i = '0;
  logic [5:0] len_i = '0;
  logic       tx_valid_o;
  logic       tx_ready_i = 1'b0;
  logic [7:0] tx_data_o;
  logic       tx_cmd_o;
  logic       done_o;
  logic       err_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit rand_ready = 1'b0;
  bit stall_prev = 1'b0;
  logic [8:0] stall_word = '0;
  int hold_viol = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;

  cmd_stream_player i_cmd_stream_player (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .base_i(base_i), .len_i(len_i), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .tx_cmd_o(tx_cmd_o),
    .done_o(done_o), .err_o(err_o)
  );

  // Expected table contents per R7, R8, R9.
  function automatic int tb_rom(int b, int a);
    int bw[21] = '{4,1,3,0,43,43,3,6,23,23,23,2,0,191,13,4,97,1,144,1,44};
    int gs[21] = '{5,1,3,0,43,43,19,3,6,23,23,23,1,0,63,4,97,1,144,1,44};
    if (a == 24) return 7;
    if (a < 0 || a > 20) return 0;
    return (b == 0) ? bw[a] : gs[a];
  endfunction

  // Expected stream per R3, R5, R6; returns expected error.
  function automatic bit model(int b, int base, int len);
    int p = base;
    int e = base + len;
    int n;
    exp_q.delete();
    while (p != e) begin
      n = tb_rom(b, p);
      if (n > 6 || p + n + 2 > e) return 1'b1;
      exp_q.push_back({1'b1, 8'(tb_rom(b, p + 1))});
      for (int k = 1; k <= n; k++) exp_q.push_back({1'b0, 8'(tb_rom(b, p + 1 + k))});
      p += n + 2;
    end
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tx_ready_i = rand_ready ? (($urandom % 4) != 0) : 1'b1;
    if (stall_prev && (!tx_valid_o || {tx_cmd_o, tx_data_o} != stall_word)) hold_viol++;
    stall_prev = tx_valid_o && !tx_ready_i;
    stall_word = {tx_cmd_o, tx_data_o};
    if (tx_valid_o && tx_ready_i) got_q.push_back({tx_cmd_o, tx_data_o});
    if (done_o) done_cnt++;
    if (err_o) err_cnt++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic play(int b, int base, int len, bit poke, string tag);
    bit exp_err;
    int k = 0;
    exp_err = model(b, base, len);
    @(negedge clk);
    got_q.delete(); done_cnt = 0; err_cnt = 0;
    start_i = 1'b1; mode_i = b[0]; base_i = 5'(base); len_i = 6'(len);
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R2: start during playback, different bank and window
      start_i = 1'b1; mode_i = ~b[0]; base_i = 5'd24; len_i = 6'd4;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == 0 && k < 3000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
    begin
      bit same = (got_q.size() == exp_q.size());
      int idx = -1;
      if (same) foreach (got_q[i]) if (got_q[i] != exp_q[i] && idx < 0) idx = i;
      if (idx >= 0) same = 1'b0;
      if (idx >= 0) chk(same, tag, "R3 stream byte", int'(got_q[idx]), int'(exp_q[idx]));
      else chk(same, tag, "R3 stream length", got_q.size(), exp_q.size());
    end
    chk(done_cnt == 1, tag, "R5 done pulses", done_cnt, 1);
    chk(err_cnt == int'(exp_err), tag, "R6 error pulses", err_cnt, int'(exp_err));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!tx_valid_o && !done_o && !err_o, "R1", "reset outputs",
        int'({tx_valid_o, done_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tx_valid_o && !done_o && !err_o, "R1", "idle outputs",
        int'({tx_valid_o, done_o, err_o}), 0);

    play(0, 0, 11, 1'b0, "R7 bw pre");
    chk(got_q.size() > 0 && got_q[0] == 9'h101, "R7", "bw power opcode",
        got_q.size() > 0 ? int'(got_q[0]) : -1, 9'h101);
    play(0, 11, 10, 1'b0, "R7 bw post");
    chk(got_q.size() > 2 && got_q[1] == 9'h0BF && got_q[2] == 9'h00D, "R7",
        "bw panel params", got_q.size() > 1 ? int'(got_q[1]) : -1, 9'h0BF);
    play(1, 0, 12, 1'b0, "R8 gs pre");
    play(1, 12, 9, 1'b0, "R8 gs post");
    chk(got_q.size() > 1 && got_q[1] == 9'h03F, "R8", "gs panel param",
        got_q.size() > 1 ? int'(got_q[1]) : -1, 9'h03F);
    play(0, 5, 0, 1'b0, "R5 zero length");
    chk(got_q.size() == 0, "R5", "no byte for zero length", got_q.size(), 0);
    play(0, 0, 3, 1'b0, "R6 overrun first");
    play(1, 0, 8, 1'b0, "R6 overrun second");
    play(0, 24, 8, 1'b0, "R6 R9 count above limit");
    play(1, 25, 7, 1'b0, "R9 zero records to end");
    rand_ready = 1'b1;
    play(0, 0, 21, 1'b1, "R2 R4 bw full with poke");
    play(1, 0, 21, 1'b0, "R4 gs full stalled");
    for (int r = 0; r < 24; r++) begin
      int b = int'($urandom % 2);
      int bs = int'($urandom % 32);
      int ln = int'($urandom % (33 - bs));
      play(b, bs, ln, 1'b0, "R3 random window");
    end
    chk(hold_viol == 0, "R4", "hold under back-pressure", hold_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule